// File: doc/BRIEF.md
# Card Clock Generator with Flow-Control Gating

This block produces the serial clock for a memory-card link from the system master clock. A programmable divider sets the half-period of the card clock in master cycles, so every ratio it produces is even and the duty cycle is exactly 50 %. A second, optional power-save stage stretches both halves by a further power of two.

The clock can be frozen on the fly when the internal data FIFO cannot keep up. During a read the clock stops while the FIFO is full. During a write it stops while the FIFO is empty. Each direction has its own guard enable. A stop only takes effect once a low phase has run its full length, and a running high phase is never cut short, so the card never sees a runt pulse. Divider settings are picked up at each rising edge, so a period already in progress keeps its old length.

Single-cycle rise and fall strobes in the master-clock domain let the command and data engines act on card-clock edges without resampling the clock.

Top module: `card_clk_gen`

## Requirements
- R1: With the power-save stage inactive, the card clock period is 2*(div_sel+1) master cycles, with a high phase and a low phase of div_sel+1 cycles each.
- R2: When pws_en is 1 and pws_sel is nonzero, both phases are multiplied by 2**pws_sel, giving a period of 2*(div_sel+1)*2**pws_sel cycles.
- R3: When pws_en is 1 and pws_sel is 0, the clock keeps the period given in R1.
- R4: When rd_guard_en=1, dir_rd=1 and fifo_full=1, the clock is held low once the current low phase is complete. The first rising edge comes on the master edge after the stall condition is removed.
- R5: When wr_guard_en=1, dir_wr=1 and fifo_empty=1, the clock is held low in the same way as in R4.
- R6: When a direction's guard enable is 0, or its direction input is 0, that direction's FIFO flag has no effect and the clock keeps its programmed period.
- R7: A stall that arrives during a high phase does not shorten it: the high phase lasts its full length before the clock is held low.
- R8: A change to div_sel, pws_sel or pws_en first takes effect at the next rising edge. The period that is in progress keeps its old length.
- R9: rise_stb is high for exactly the one master cycle in which card_clk is first high, and fall_stb for the one cycle in which card_clk is first low. They are never high together.
- R10: After reset, card_clk, rise_stb and fall_stb are 0. The clock stays low while clk_en is 0, and the first rising edge comes on the master edge that samples clk_en=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Card clock run enable |
| div_sel | input | DIV_W (8) | Main divider setting; half-period = div_sel+1 |
| pws_sel | input | PWS_W (3) | Power-save exponent; multiplier 2**pws_sel |
| pws_en | input | 1 | Power-save stage enable |
| rd_guard_en | input | 1 | Stop clock on full FIFO during reads |
| wr_guard_en | input | 1 | Stop clock on empty FIFO during writes |
| dir_rd | input | 1 | Read transfer in progress |
| dir_wr | input | 1 | Write transfer in progress |
| fifo_full | input | 1 | Data FIFO has no free space |
| fifo_empty | input | 1 | Data FIFO holds no data |
| card_clk | output | 1 | Card clock |
| rise_stb | output | 1 | One-cycle strobe on card clock rising edge |
| fall_stb | output | 1 | One-cycle strobe on card clock falling edge |

## Verification
The assertions take for granted that every input is synchronous to the master clock and changes only between edges. They also assume that the divider fields are held stable from one rising edge to the next, since the high-phase length check compares against the half-period latched at the rise. The stimulus drives all inputs on falling master edges. It changes the divider fields at most once per measured period, and it raises and clears the FIFO flags only at chosen points relative to the strobes, so every stall begins and ends on a known phase.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;
  // Half-period length for the given divider, exponent and enable.
  // Power-save only applies when the exponent is nonzero.
  function automatic int unsigned half_cycles(input int unsigned div,
                                              input int unsigned pws,
                                              input bit pws_on);
    int unsigned h;
    h = div + 1;
    if (pws_on && pws != 0) h = h << pws;
    return h;
  endfunction
endpackage

// File: rtl/ccg_ratio.sv
module ccg_ratio #(
  parameter int DIV_W  = 8,
  parameter int PWS_W  = 3,
  parameter int HALF_W = DIV_W + (1 << PWS_W)
) (
  input  logic [DIV_W-1:0]  div_sel,
  input  logic [PWS_W-1:0]  pws_sel,
  input  logic              pws_en,
  output logic [HALF_W-1:0] half_len
);
  function automatic logic [HALF_W-1:0] calc_half(input logic [DIV_W-1:0] d,
                                                  input logic [PWS_W-1:0] p,
                                                  input logic             en);
    logic [HALF_W-1:0] base;
    base = HALF_W'(d) + HALF_W'(1);
    if (en && (p != '0)) base = base << p;
    return base;
  endfunction

  always_comb half_len = calc_half(div_sel, pws_sel, pws_en);
endmodule

// File: rtl/ccg_guard.sv
module ccg_guard (
  input  logic clk_en,
  input  logic rd_guard_en,
  input  logic wr_guard_en,
  input  logic dir_rd,
  input  logic dir_wr,
  input  logic fifo_full,
  input  logic fifo_empty,
  output logic stall,
  output logic go
);
  logic rd_stop, wr_stop;
  always_comb begin
    rd_stop = rd_guard_en & dir_rd & fifo_full;
    wr_stop = wr_guard_en & dir_wr & fifo_empty;
    stall   = rd_stop | wr_stop;
    go      = clk_en & ~stall;
  end
endmodule

// File: rtl/ccg_phase.sv
module ccg_phase #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] half_len,
  input  logic              go,
  output logic              clk_q,
  output logic              rise_q,
  output logic              fall_q,
  output logic [HALF_W-1:0] half_q,
  output logic              phase_end
);
  logic [HALF_W-1:0] cnt;

  assign phase_end = (cnt == half_q - HALF_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q  <= 1'b0;
      cnt    <= '0;
      half_q <= HALF_W'(1);
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (clk_q) begin
        if (phase_end) begin
          clk_q  <= 1'b0;
          cnt    <= '0;
          fall_q <= 1'b1;
        end else begin
          cnt <= cnt + HALF_W'(1);
        end
      end else if (!phase_end) begin
        cnt <= cnt + HALF_W'(1);
      end else if (go) begin
        clk_q  <= 1'b1;
        cnt    <= '0;
        half_q <= half_len;
        rise_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen #(
  parameter int DIV_W = 8,
  parameter int PWS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [PWS_W-1:0] pws_sel,
  input  logic             pws_en,
  input  logic             rd_guard_en,
  input  logic             wr_guard_en,
  input  logic             dir_rd,
  input  logic             dir_wr,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  output logic             card_clk,
  output logic             rise_stb,
  output logic             fall_stb
);
  localparam int HALF_W = DIV_W + (1 << PWS_W);

  logic [HALF_W-1:0] half_len;
  logic [HALF_W-1:0] half_q;
  logic              stall, go, phase_end;

  ccg_ratio #(.DIV_W(DIV_W), .PWS_W(PWS_W), .HALF_W(HALF_W)) u_ratio (
    .div_sel(div_sel), .pws_sel(pws_sel), .pws_en(pws_en), .half_len(half_len)
  );

  ccg_guard u_guard (
    .clk_en(clk_en), .rd_guard_en(rd_guard_en), .wr_guard_en(wr_guard_en),
    .dir_rd(dir_rd), .dir_wr(dir_wr), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .stall(stall), .go(go)
  );

  ccg_phase #(.HALF_W(HALF_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .half_len(half_len), .go(go),
    .clk_q(card_clk), .rise_q(rise_stb), .fall_q(fall_stb),
    .half_q(half_q), .phase_end(phase_end)
  );
endmodule

// File: rtl/ccg_chk.sv
module ccg_chk #(
  parameter int HALF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              card_clk,
  input logic              rise_stb,
  input logic              fall_stb,
  input logic              stall,
  input logic [HALF_W-1:0] half_q
);
  logic [HALF_W:0] ph_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_len <= '0;
    else if (card_clk != (rise_stb ? 1'b1 : fall_stb ? 1'b0 : card_clk)) ph_len <= '0;
    else if (rise_stb || fall_stb) ph_len <= (HALF_W+1)'(1);
    else if (ph_len != '1) ph_len <= ph_len + 1'b1;
  end

  AST_HIGH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (ph_len == {1'b0, half_q}));                          // R7
  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_clk && stall) |=> !card_clk);                               // R4
  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_clk && !clk_en) |=> !card_clk);                             // R10
  AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (card_clk && !$past(card_clk)));                      // R9
  AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (!card_clk && $past(card_clk)));                      // R9
  AST_EDGE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (card_clk != $past(card_clk)) |-> (rise_stb || fall_stb));         // R9
  AST_HALF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (card_clk && !rise_stb) |-> $stable(half_q));                      // R8
endmodule

bind card_clk_gen ccg_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .card_clk(card_clk),
  .rise_stb(rise_stb), .fall_stb(fall_stb), .stall(stall), .half_q(half_q)
);

// File: tb/sim_card_clk_gen.sv
module sim_card_clk_gen;
  import card_clk_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b0;
  logic [7:0] div_sel = '0;
  logic [2:0] pws_sel = '0;
  logic pws_en = 1'b0, rd_guard_en = 1'b0, wr_guard_en = 1'b0;
  logic dir_rd = 1'b0, dir_wr = 1'b0, fifo_full = 1'b0, fifo_empty = 1'b0;
  logic card_clk, rise_stb, fall_stb;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  card_clk_gen u0 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .div_sel(div_sel),
    .pws_sel(pws_sel), .pws_en(pws_en), .rd_guard_en(rd_guard_en),
    .wr_guard_en(wr_guard_en), .dir_rd(dir_rd), .dir_wr(dir_wr),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .card_clk(card_clk), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  // Expected period restated from the requirements
  function automatic int exp_period(int d, int p, bit en);
    int m;
    m = (en && p > 0) ? (1 << p) : 1;
    return 2 * (d + 1) * m;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    int n = 0;
    do begin @(negedge clk); n++; end while (!rise_stb && n < 5000);
  endtask

  // Counts one full period starting at a rise strobe; returns period and high time.
  task automatic measure(output int per, output int hi);
    wait_rise();
    per = 1; hi = 1;
    forever begin
      @(negedge clk);
      if (rise_stb || per > 5000) break;
      per++;
      if (card_clk) hi++;
    end
  endtask

  task automatic set_div(int d, int p, bit en);
    div_sel = 8'(d); pws_sel = 3'(p); pws_en = en;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int per, hi, seen, d, p;
    bit e;
    void'($urandom(32'd4242));
    set_div(2, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state and hold while disabled
    chk("R10 clk after reset", card_clk, 0);
    chk("R10 strobes after reset", rise_stb | fall_stb, 0);
    seen = 0;
    repeat (20) begin @(negedge clk); seen += card_clk + rise_stb; end
    chk("R10 held low while clk_en=0", seen, 0);
    clk_en = 1'b1;
    @(negedge clk);
    chk("R10 first rise after enable", rise_stb, 1);
    chk("R9 strobe with clock high", card_clk, 1);
    @(negedge clk);
    chk("R9 strobe one cycle", rise_stb, 0);

    // R1 basic ratio and duty
    measure(per, hi);
    chk("R1 period div=2", per, 6);
    chk("R1 high time div=2", hi, 3);
    set_div(0, 0, 0);
    wait_rise();
    measure(per, hi);
    chk("R1 period div=0", per, 2);

    // R2 power-save stage
    set_div(1, 2, 1);
    wait_rise();
    measure(per, hi);
    chk("R2 period div=1 pws=2", per, 16);
    chk("R2 high time", hi, 8);

    // R3 power-save enabled with zero exponent
    set_div(3, 0, 1);
    wait_rise();
    measure(per, hi);
    chk("R3 pws_sel=0 keeps normal", per, 8);

    // R8 change mid-period: old period completes, then new
    set_div(3, 0, 0);
    wait_rise();
    @(negedge clk);
    set_div(1, 0, 0);
    per = 2;
    forever begin @(negedge clk); if (rise_stb) break; per++; end
    chk("R8 old period kept", per, 8);
    per = 1;
    forever begin @(negedge clk); if (rise_stb) break; per++; end
    chk("R8 new period used", per, 4);

    // R7 and R4: read stall during high phase
    set_div(3, 0, 0);
    rd_guard_en = 1'b1; dir_rd = 1'b1;
    wait_rise();
    wait_rise();
    fifo_full = 1'b1;
    hi = 1;
    forever begin @(negedge clk); if (!card_clk) break; hi++; end
    chk("R7 high phase not cut", hi, 4);
    seen = 0;
    repeat (40) begin @(negedge clk); seen += rise_stb + card_clk; end
    chk("R4 held low on full FIFO", seen, 0);
    fifo_full = 1'b0;
    @(negedge clk);
    chk("R4 resumes next edge", rise_stb, 1);

    // R6 read guard off / wrong direction
    rd_guard_en = 1'b0; fifo_full = 1'b1;
    measure(per, hi);
    chk("R6 read guard off free-running", per, 8);
    rd_guard_en = 1'b1; dir_rd = 1'b0; dir_wr = 1'b1;
    measure(per, hi);
    chk("R6 full flag ignored on write", per, 8);
    fifo_full = 1'b0;

    // R5 write stall on empty FIFO
    wr_guard_en = 1'b1;
    wait_rise();
    fifo_empty = 1'b1;
    seen = 0;
    repeat (12) @(negedge clk);
    repeat (30) begin @(negedge clk); seen += rise_stb + card_clk; end
    chk("R5 held low on empty FIFO", seen, 0);
    fifo_empty = 1'b0;
    @(negedge clk);
    chk("R5 resumes next edge", rise_stb, 1);
    wr_guard_en = 1'b0; fifo_empty = 1'b1;
    measure(per, hi);
    chk("R6 write guard off free-running", per, 8);
    fifo_empty = 1'b0; dir_wr = 1'b0; rd_guard_en = 1'b0;

    // R1 R2 R3 random ratios
    for (int i = 0; i < 24; i++) begin
      d = int'($urandom % 6);
      p = int'($urandom % 4);
      e = 1'($urandom % 2);
      set_div(d, p, e);
      wait_rise();
      measure(per, hi);
      chk("R2 random period", per, exp_period(d, p, e));
      chk("R1 random duty", hi, exp_period(d, p, e) / 2);
    end

    // R9 strobes never together over a run
    seen = 0;
    set_div(0, 0, 0);
    repeat (50) begin @(negedge clk); seen += (rise_stb & fall_stb); end
    chk("R9 strobes exclusive", seen, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule